// File: doc/BRIEF.md
# Display Mode Register Bank

A memory-mapped register bank for a linear-framebuffer display controller. Software programs the display geometry through an array of 16-bit mode registers (enable, pixel depth, horizontal and vertical resolution, virtual width and height, bank, X and Y panning offsets). A register's index is its byte address shifted right by one. Two indices are read-only in effect: the identification index returns a fixed ID code, and the memory-size index returns the video memory size in 64 KiB units. Indices beyond the implemented array read as all ones and drop writes.

The upper half of the address space is a 32-bit extension window. It reports its own size and holds the framebuffer byte-order flag, which changes only when one of two exact magic words is written. Every stored mode register and the byte-order flag are exported on flat output buses to the scan-out and pixel-format logic downstream. Reads return data one clock after the read strobe.

Top module: `disp_mode_regs`

## Requirements
- R1: With addr_i[7]=0 the register index is addr_i[6:1] (addr_i[0] is ignored); a write at index 0..10 stores wdata_i[15:0], and a read of index 1..9 returns the stored value zero-extended to 32 bits.
- R2: A read of index 0 returns 0x0000B0C5 whatever was written to that index.
- R3: A read of index 10 returns the video memory size divided by 65536 (0x00000100 for the default 16 MiB).
- R4: A read of any index 11..63 returns 0xFFFFFFFF.
- R5: A write to any index 11..63 changes no output of the block.
- R6: With addr_i[7]=1, a read at window offset addr_i[6:0]=0 returns 8 (window size), and at offset 4 returns 0x1E1E1E1E while the flag is little-endian and 0xBEBEBEBE while it is big-endian.
- R7: A write at window offset 4 sets big_endian_o only for wdata_i=0xBEBEBEBE, clears it only for wdata_i=0x1E1E1E1E, and leaves it unchanged for any other value.
- R8: A read at any window offset other than 0 and 4 returns zero; a write there changes no output.
- R9: rdata_o is registered: it takes the new value on the clock edge where re_i is high and holds otherwise; a read and a write to the same register in one cycle returns the old contents.
- R10: After reset every mode register, big_endian_o and rdata_o are zero.
- R11: regs_o carries stored register k in bits [16k+15:16k] for k=0..10 (including indices 0 and 10), updated on the clock edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address; bit 7 selects the extension window |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the cycle after re_i |
| regs_o | output | 176 | Stored mode registers, 16 bits each |
| big_endian_o | output | 1 | Framebuffer byte-order flag |

## Verification
The assertions watch every cycle for the synthesized reads (ID, memory size, window size, byte-order word), the all-ones answer outside the array, dropped out-of-range writes, the magic-word rules of the flag and the holding of rdata_o between reads. Only the bench scenarios show that a stored value makes the round trip through regs_o and back to rdata_o, that addr_i[0] is ignored, that a same-cycle read and write returns the old contents, and the reset values.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int REG_W    = 16;
  localparam int BUS_W    = 32;
  localparam int NUM_REGS = 11;

  localparam int IDX_ID    = 0;
  localparam int IDX_HRES  = 1;
  localparam int IDX_VRES  = 2;
  localparam int IDX_DEPTH = 3;
  localparam int IDX_EN    = 4;
  localparam int IDX_BANK  = 5;
  localparam int IDX_VWID  = 6;
  localparam int IDX_VHGT  = 7;
  localparam int IDX_XOFF  = 8;
  localparam int IDX_YOFF  = 9;
  localparam int IDX_VMEM  = 10;
endpackage

// File: rtl/dmr_decode.sv
module dmr_decode #(
  parameter int AW       = 8,
  parameter int NUM_REGS = dmr_pkg::NUM_REGS,
  localparam int IW      = AW - 2,
  localparam int OW      = AW - 1
) (
  input  logic [AW-1:0] addr_i,
  output logic          mode_sel_o,
  output logic          ext_sel_o,
  output logic [IW-1:0] idx_o,
  output logic          in_range_o,
  output logic [OW-1:0] ext_off_o
);
  assign mode_sel_o = ~addr_i[AW-1];
  assign ext_sel_o  = addr_i[AW-1];
  assign idx_o      = addr_i[AW-2:1];
  assign ext_off_o  = addr_i[AW-2:0];
  assign in_range_o = ({1'b0, idx_o} < (IW+1)'(NUM_REGS));
endmodule

// File: rtl/dmr_mode_file.sv
module dmr_mode_file
  import dmr_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      sel_i,
  input  logic [IW-1:0]             idx_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (we_i && sel_i && idx_i == IW'(k))   q <= wdata_i;
    end
    assign regs_o[k*REG_W +: REG_W] = q;
  end
endmodule

// File: rtl/dmr_ext_regs.sv
module dmr_ext_regs
  import dmr_pkg::*;
#(
  parameter int               OW       = 7,
  parameter int               BO_OFF   = 4,
  parameter logic [BUS_W-1:0] LE_MAGIC = 32'h1e1e1e1e,
  parameter logic [BUS_W-1:0] BE_MAGIC = 32'hbebebebe
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [OW-1:0]    off_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             big_endian_o
);
  logic hit;
  assign hit = we_i && sel_i && off_i == OW'(BO_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          big_endian_o <= 1'b0;
    else if (hit && wdata_i == BE_MAGIC)  big_endian_o <= 1'b1;
    else if (hit && wdata_i == LE_MAGIC)  big_endian_o <= 1'b0;
  end
endmodule

// File: rtl/dmr_read_mux.sv
module dmr_read_mux
  import dmr_pkg::*;
#(
  parameter int               IW        = 6,
  parameter int               OW        = 7,
  parameter logic [REG_W-1:0] ID_CODE   = 16'hB0C5,
  parameter logic [REG_W-1:0] VMEM_UNIT = 16'h0100,
  parameter int               EXT_SIZE  = 8,
  parameter int               SIZE_OFF  = 0,
  parameter int               BO_OFF    = 4,
  parameter logic [BUS_W-1:0] LE_MAGIC  = 32'h1e1e1e1e,
  parameter logic [BUS_W-1:0] BE_MAGIC  = 32'hbebebebe
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      re_i,
  input  logic                      mode_sel_i,
  input  logic [IW-1:0]             idx_i,
  input  logic                      in_range_i,
  input  logic [OW-1:0]             off_i,
  input  logic [NUM_REGS*REG_W-1:0] regs_i,
  input  logic                      big_endian_i,
  output logic [BUS_W-1:0]          rdata_o
);
  logic [REG_W-1:0] stored;
  logic [BUS_W-1:0] nxt;

  always_comb begin
    stored = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (idx_i == IW'(k)) stored = regs_i[k*REG_W +: REG_W];
  end

  always_comb begin
    if (mode_sel_i) begin
      if (!in_range_i)                 nxt = '1;
      else if (idx_i == IW'(IDX_ID))   nxt = BUS_W'(ID_CODE);
      else if (idx_i == IW'(IDX_VMEM)) nxt = BUS_W'(VMEM_UNIT);
      else                             nxt = BUS_W'(stored);
    end else begin
      if (off_i == OW'(SIZE_OFF))      nxt = BUS_W'(EXT_SIZE);
      else if (off_i == OW'(BO_OFF))   nxt = big_endian_i ? BE_MAGIC : LE_MAGIC;
      else                             nxt = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= nxt;
  end
endmodule

// File: rtl/disp_mode_regs.sv
module disp_mode_regs
  import dmr_pkg::*;
#(
  parameter int               AW         = 8,
  parameter int unsigned      VMEM_BYTES = 32'h0100_0000,
  parameter logic [REG_W-1:0] ID_CODE    = 16'hB0C5,
  parameter int               EXT_SIZE   = 8,
  parameter int               SIZE_OFF   = 0,
  parameter int               BO_OFF     = 4,
  parameter logic [BUS_W-1:0] LE_MAGIC   = 32'h1e1e1e1e,
  parameter logic [BUS_W-1:0] BE_MAGIC   = 32'hbebebebe
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             addr_i,
  input  logic [BUS_W-1:0]          wdata_i,
  input  logic                      we_i,
  input  logic                      re_i,
  output logic [BUS_W-1:0]          rdata_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o,
  output logic                      big_endian_o
);
  localparam int               IW        = AW - 2;
  localparam int               OW        = AW - 1;
  localparam logic [REG_W-1:0] VMEM_UNIT = REG_W'(VMEM_BYTES / 65536);

  logic          mode_sel, ext_sel, in_range;
  logic [IW-1:0] idx;
  logic [OW-1:0] ext_off;
  logic          unused_hi;

  assign unused_hi = ^wdata_i[BUS_W-1:REG_W];

  dmr_decode #(.AW(AW), .NUM_REGS(NUM_REGS)) i_decode (
    .addr_i     (addr_i),
    .mode_sel_o (mode_sel),
    .ext_sel_o  (ext_sel),
    .idx_o      (idx),
    .in_range_o (in_range),
    .ext_off_o  (ext_off)
  );

  dmr_mode_file #(.IW(IW)) i_mode_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .sel_i   (mode_sel),
    .idx_i   (idx),
    .wdata_i (wdata_i[REG_W-1:0]),
    .regs_o  (regs_o)
  );

  dmr_ext_regs #(
    .OW(OW), .BO_OFF(BO_OFF), .LE_MAGIC(LE_MAGIC), .BE_MAGIC(BE_MAGIC)
  ) i_ext_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .sel_i        (ext_sel),
    .off_i        (ext_off),
    .wdata_i      (wdata_i),
    .big_endian_o (big_endian_o)
  );

  dmr_read_mux #(
    .IW(IW), .OW(OW), .ID_CODE(ID_CODE), .VMEM_UNIT(VMEM_UNIT),
    .EXT_SIZE(EXT_SIZE), .SIZE_OFF(SIZE_OFF), .BO_OFF(BO_OFF),
    .LE_MAGIC(LE_MAGIC), .BE_MAGIC(BE_MAGIC)
  ) i_read_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .re_i         (re_i),
    .mode_sel_i   (mode_sel),
    .idx_i        (idx),
    .in_range_i   (in_range),
    .off_i        (ext_off),
    .regs_i       (regs_o),
    .big_endian_i (big_endian_o),
    .rdata_o      (rdata_o)
  );
endmodule

// File: rtl/dmr_checker.sv
module dmr_checker
  import dmr_pkg::*;
#(
  parameter int               AW        = 8,
  parameter logic [REG_W-1:0] ID_CODE   = 16'hB0C5,
  parameter int unsigned      VMEM_B    = 32'h0100_0000,
  parameter int               EXT_SIZE  = 8,
  parameter int               SIZE_OFF  = 0,
  parameter int               BO_OFF    = 4,
  parameter logic [BUS_W-1:0] LE_MAGIC  = 32'h1e1e1e1e,
  parameter logic [BUS_W-1:0] BE_MAGIC  = 32'hbebebebe
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [AW-1:0]             addr_i,
  input logic [BUS_W-1:0]          wdata_i,
  input logic                      we_i,
  input logic                      re_i,
  input logic [BUS_W-1:0]          rdata_o,
  input logic [NUM_REGS*REG_W-1:0] regs_o,
  input logic                      big_endian_o
);
  logic         m_win, e_win, oor;
  logic [AW-3:0] c_idx;
  logic [AW-2:0] c_off;
  logic          bo_wr;

  assign m_win = !addr_i[AW-1];
  assign e_win = addr_i[AW-1];
  assign c_idx = addr_i[AW-2:1];
  assign c_off = addr_i[AW-2:0];
  assign oor   = int'(c_idx) >= NUM_REGS;
  assign bo_wr = we_i && e_win && c_off == (AW-1)'(BO_OFF);

  AST_READ_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && m_win && c_idx == '0 |=> rdata_o == BUS_W'(ID_CODE));  // R2
  AST_READ_VMEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && m_win && int'(c_idx) == IDX_VMEM |=> rdata_o == BUS_W'(VMEM_B / 65536));  // R3
  AST_OOR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && m_win && oor |=> rdata_o == '1);  // R4
  AST_OOR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && m_win && oor |=> $stable(regs_o) && $stable(big_endian_o));  // R5
  AST_EXT_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && e_win && c_off == (AW-1)'(SIZE_OFF) |=> rdata_o == BUS_W'(EXT_SIZE));  // R6
  AST_ORDER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && e_win && c_off == (AW-1)'(BO_OFF) |=>
      rdata_o == ($past(big_endian_o) ? BE_MAGIC : LE_MAGIC));  // R6
  AST_BE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_wr && wdata_i == BE_MAGIC |=> big_endian_o);  // R7
  AST_LE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_wr && wdata_i == LE_MAGIC |=> !big_endian_o);  // R7
  AST_BO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bo_wr && (wdata_i == BE_MAGIC || wdata_i == LE_MAGIC)) |=> $stable(big_endian_o));  // R7
  AST_EXT_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && e_win && c_off != (AW-1)'(SIZE_OFF) && c_off != (AW-1)'(BO_OFF)
      |=> rdata_o == '0);  // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));  // R9
  AST_EXT_NO_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && e_win |=> $stable(regs_o));  // R8
endmodule

bind disp_mode_regs dmr_checker #(
  .AW(AW), .ID_CODE(ID_CODE), .VMEM_B(VMEM_BYTES), .EXT_SIZE(EXT_SIZE),
  .SIZE_OFF(SIZE_OFF), .BO_OFF(BO_OFF), .LE_MAGIC(LE_MAGIC), .BE_MAGIC(BE_MAGIC)
) i_dmr_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .regs_o(regs_o),
  .big_endian_o(big_endian_o)
);

// File: tb/test_disp_mode_regs.sv
module test_disp_mode_regs;
  localparam int NR = 11;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic         we_i = 1'b0;
  logic         re_i = 1'b0;
  logic [31:0]  rdata_o;
  logic [NR*16-1:0] regs_o;
  logic         big_endian_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NR];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;
  logic [31:0] last_rd = '0;

  always #4 clk = ~clk;

  disp_mode_regs i_disp_mode_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .regs_o(regs_o),
    .big_endian_o(big_endian_o)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data the cycle after each read strobe
  always @(posedge clk) rd_pend <= re_i;
  initial forever begin
    @(negedge clk);
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=%0h expected=none", rdata_o);
      end else begin
        last_rd = exp_q.pop_front();
        chk(tag_q.pop_front(), 256'(rdata_o), 256'(last_rd));
      end
    end
  end

  function automatic logic [NR*16-1:0] flat();
    logic [NR*16-1:0] f;
    for (int k = 0; k < NR; k++) f[k*16 +: 16] = model[k];
    return f;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    if (!a[7] && a[6:1] < NR) model[a[6:1]] = d[15:0];
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr_i = a; re_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    re_i = 1'b0;
  endtask

  task automatic rw(input logic [7:0] a, input logic [31:0] d, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1; re_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    if (a[6:1] < NR) model[a[6:1]] = d[15:0];
    @(negedge clk);
    we_i = 1'b0; re_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    chk("R10 regs", 256'(regs_o), 256'(0));
    chk("R10 flag", 256'(big_endian_o), 256'(0));
    chk("R10 rdata", 256'(rdata_o), 256'(0));
    rst_ni = 1'b1;
    @(negedge clk);

    wr(8'h02, 32'h1234_0280);
    rd(8'h02, 32'h0000_0280, "R1 hres");
    rd(8'h03, 32'h0000_0280, "R1 odd byte");
    wr(8'h06, 32'h0000_0020);
    wr(8'h0C, 32'h0000_0400);
    wr(8'h12, 32'hFFFF_FFFF);
    rd(8'h12, 32'h0000_FFFF, "R1 yoff");
    rd(8'h06, 32'h0000_0020, "R1 depth");
    chk("R11 export", 256'(regs_o), 256'(flat()));

    wr(8'h00, 32'h0000_5555);
    rd(8'h00, 32'h0000_B0C5, "R2 id");
    chk("R11 id slot", 256'(regs_o[15:0]), 256'(16'h5555));
    wr(8'h14, 32'h0000_7777);
    rd(8'h14, 32'h0000_0100, "R3 vmem");
    chk("R11 vmem slot", 256'(regs_o[175:160]), 256'(16'h7777));

    rd(8'h16, 32'hFFFF_FFFF, "R4 idx11");
    rd(8'h7E, 32'hFFFF_FFFF, "R4 idx63");
    wr(8'h16, 32'h0000_ABCD);
    wr(8'h7F, 32'h0000_ABCD);
    chk("R5 regs", 256'(regs_o), 256'(flat()));
    chk("R5 flag", 256'(big_endian_o), 256'(0));

    rd(8'h80, 32'd8, "R6 size");
    rd(8'h84, 32'h1e1e1e1e, "R6 le word");
    wr(8'h84, 32'hbebebebe);
    chk("R7 set", 256'(big_endian_o), 256'(1));
    rd(8'h84, 32'hbebebebe, "R6 be word");
    wr(8'h84, 32'h1234_5678);
    chk("R7 keep", 256'(big_endian_o), 256'(1));
    wr(8'h84, 32'h1e1e1e1e);
    chk("R7 clear", 256'(big_endian_o), 256'(0));
    wr(8'h84, 32'hbebebebf);
    chk("R7 near miss", 256'(big_endian_o), 256'(0));
    wr(8'h84, 32'hbebebebe);
    wr(8'h88, 32'h1e1e1e1e);
    wr(8'h80, 32'h1e1e1e1e);
    chk("R8 flag", 256'(big_endian_o), 256'(1));
    chk("R8 regs", 256'(regs_o), 256'(flat()));
    rd(8'h88, 32'h0, "R8 other");
    rd(8'h85, 32'h0, "R8 unaligned");

    rw(8'h0A, 32'h0000_0777, 32'h0, "R9 rd+wr old");
    rd(8'h0A, 32'h0000_0777, "R9 new");
    repeat (4) @(negedge clk);
    chk("R9 hold", 256'(rdata_o), 256'(last_rd));

    repeat (2) @(negedge clk);
    chk("R9 queue drained", 256'(exp_q.size()), 256'(0));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule